// File: doc/BRIEF.md
# PLL Dynamic Reconfiguration Sequencer

This block loads a PLL configuration image into three PLL reconfiguration ports with no processor in the loop. It holds two images, each 32 words of 16 bits. One image sets the VCO to 20 times the pixel clock and the other sets it to 10 times. The block chooses an image from a requested pixel-clock frequency, or it forces the 20x image. It then writes a window of words to each port in turn. Every access presents an address and data, pulses a strobe for one cycle, and waits for that port's ready before it moves on. The window leaves out the leading words, which depend on where the PLL is placed, and the trailing words.

A readback operation walks all 32 words of each port in the same port order. For each word it hands the captured value out on a valid strobe, tagged with the port and word index. The frequency input is an unsigned count of 100 kHz steps.

Top module: `pll_reconfig_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy_o`, `done_o`, `err_low_o`, `err_high_o`, `rb_valid_o` and every read and write strobe are low.
- R2: A write operation writes word indices FIRST_WORD (6) through LAST_WORD (29) in ascending order to each port, so words 0 to 5, 30 and 31 are never written. The address equals the word index. With the default parameters, word k of the 20x image is (0x2000 + 0x0313·k) mod 2^16 and word k of the 10x image is (0x1000 + 0x0313·k) mod 2^16.
- R3: Ports are served in index order 0, 1, 2, and each port's last access completes before the first strobe to the next port. Only the active port sees a non-zero address, data or strobe.
- R4: Each access strobe lasts exactly one cycle, and at most one strobe is high at a time. The next strobe comes only after the active port has raised ready while the sequencer waits for it. A ready from any other port has no effect.
- R5: When `force_20x_i` is 1, a write operation uses the 20x image for any `freq_i` value, including values outside both bands, and raises no error.
- R6: When `force_20x_i` is 0, a `freq_i` from 200 to 450 selects the 20x image and a `freq_i` from 451 to 1000 selects the 10x image.
- R7: When `force_20x_i` is 0, a write request with `freq_i` below 200 pulses `err_low_o`, and one above 1000 pulses `err_high_o`. The pulse comes together with `done_o` in the cycle after `start_i`, and no strobe is issued.
- R8: A readback (`rd_mode_i` = 1) issues read strobes for words 0 to 31 on ports 0, 1 and 2 in that order, whatever `freq_i` and `force_20x_i` are. The cycle after each accepted ready, `rb_valid_o` pulses with the port index, the word index and the port's read data.
- R9: `busy_o` is high from the cycle after an accepted start until the last ready is accepted. `done_o` then pulses for one cycle with `busy_o` low. A `start_i` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launches an operation when idle |
| rd_mode_i | input | 1 | 1 = readback, 0 = write image |
| force_20x_i | input | 1 | 1 = always use the 20x image |
| freq_i | input | FW (12) | Requested pixel clock in 100 kHz steps |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| err_low_o | output | 1 | Frequency below the usable range (pulses with done) |
| err_high_o | output | 1 | Frequency above the usable range (pulses with done) |
| pll_addr_o | output | NPORT*5 | Per-port word address |
| pll_wdata_o | output | NPORT*16 | Per-port write data |
| pll_we_o | output | NPORT | Per-port write strobe |
| pll_rd_o | output | NPORT | Per-port read strobe |
| pll_rdy_i | input | NPORT | Per-port access-complete pulse |
| pll_rdata_i | input | NPORT*16 | Per-port read data |
| rb_valid_o | output | 1 | Readback word valid |
| rb_port_o | output | PW (2) | Port of the readback word |
| rb_word_o | output | 5 | Word index of the readback word |
| rb_data_o | output | 16 | Readback value |

## Verification
The bench aims at the band edges 199, 200, 450, 451, 1000 and 1001. A classifier that is off by one there would write the wrong image or raise an error where none is due. It injects stray ready pulses on ports that are not being served. A sequencer that listened to the wrong ready would issue a new strobe before the active access had completed. It re-pulses start with different settings in the middle of an operation. A design that accepted it would change the image or the access count. Readback checks that all 32 words come back from each port in order, so a design that reused the write window would show missing words 0 to 5, 30 and 31.

// File: rtl/pll_reconfig_pkg.sv
package pll_reconfig_pkg;

  localparam int IMG_WORDS = 32;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = $clog2(IMG_WORDS);
  localparam int IMG_BITS  = IMG_WORDS * DATA_W;

  typedef enum logic [1:0] {
    BAND_LOW,
    BAND_20X,
    BAND_10X,
    BAND_HIGH
  } band_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } seq_state_e;

  // Arithmetic image: word k = base + step*k (mod 2^16)
  function automatic logic [IMG_BITS-1:0] make_image(input logic [DATA_W-1:0] base,
                                                     input logic [DATA_W-1:0] step);
    logic [IMG_BITS-1:0] img;
    img = '0;
    for (int k = 0; k < IMG_WORDS; k++) begin
      img[k*DATA_W +: DATA_W] = base + step * DATA_W'(k);
    end
    return img;
  endfunction

  // Band decision on a frequency in 100 kHz steps
  function automatic band_e classify(input int unsigned f,
                                     input int unsigned lo_f,
                                     input int unsigned split_f,
                                     input int unsigned hi_f);
    if (f < lo_f)         return BAND_LOW;
    else if (f <= split_f) return BAND_20X;
    else if (f <= hi_f)    return BAND_10X;
    else                   return BAND_HIGH;
  endfunction

endpackage

// File: rtl/pll_band_sel.sv
module pll_band_sel
  import pll_reconfig_pkg::*;
#(
  parameter int FW      = 12,
  parameter int LO_F    = 200,
  parameter int SPLIT_F = 450,
  parameter int HI_F    = 1000
) (
  input  logic [FW-1:0] freq_i,
  input  logic          force_i,
  output logic          use_10x_o,
  output logic          err_low_o,
  output logic          err_high_o
);

  band_e band;

  always_comb begin
    band = classify(32'(freq_i), LO_F, SPLIT_F, HI_F);
    if (force_i) begin
      use_10x_o  = 1'b0;
      err_low_o  = 1'b0;
      err_high_o = 1'b0;
    end else begin
      use_10x_o  = (band == BAND_10X);
      err_low_o  = (band == BAND_LOW);
      err_high_o = (band == BAND_HIGH);
    end
  end

endmodule

// File: rtl/pll_image_rom.sv
module pll_image_rom
  import pll_reconfig_pkg::*;
#(
  parameter logic [IMG_BITS-1:0] IMG_A = make_image(16'h2000, 16'h0313),
  parameter logic [IMG_BITS-1:0] IMG_B = make_image(16'h1000, 16'h0313)
) (
  input  logic              sel_b_i,
  input  logic [ADDR_W-1:0] idx_i,
  output logic [DATA_W-1:0] word_o
);

  logic [DATA_W-1:0] word_a;
  logic [DATA_W-1:0] word_b;

  always_comb begin
    word_a = IMG_A[int'(idx_i)*DATA_W +: DATA_W];
    word_b = IMG_B[int'(idx_i)*DATA_W +: DATA_W];
    word_o = sel_b_i ? word_b : word_a;
  end

endmodule

// File: rtl/pll_port_fanout.sv
module pll_port_fanout
  import pll_reconfig_pkg::*;
#(
  parameter int NPORT = 3,
  parameter int PW    = 2
) (
  input  logic                     act_i,
  input  logic [PW-1:0]            port_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic                     we_i,
  input  logic                     rd_i,
  output logic [NPORT*ADDR_W-1:0]  pll_addr_o,
  output logic [NPORT*DATA_W-1:0]  pll_wdata_o,
  output logic [NPORT-1:0]         pll_we_o,
  output logic [NPORT-1:0]         pll_rd_o,
  input  logic [NPORT-1:0]         pll_rdy_i,
  input  logic [NPORT*DATA_W-1:0]  pll_rdata_i,
  output logic                     rdy_o,
  output logic [DATA_W-1:0]        rdata_o
);

  logic [NPORT-1:0] hit;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign hit[g] = act_i && (port_i == PW'(g));
    assign pll_addr_o[g*ADDR_W +: ADDR_W]  = hit[g] ? addr_i  : '0;
    assign pll_wdata_o[g*DATA_W +: DATA_W] = hit[g] ? wdata_i : '0;
    assign pll_we_o[g] = hit[g] & we_i;
    assign pll_rd_o[g] = hit[g] & rd_i;
  end

  always_comb begin
    rdy_o   = 1'b0;
    rdata_o = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (hit[i]) begin
        rdy_o   = pll_rdy_i[i];
        rdata_o = pll_rdata_i[i*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/pll_reconfig_seq.sv
module pll_reconfig_seq
  import pll_reconfig_pkg::*;
#(
  parameter int NPORT      = 3,
  parameter int FW         = 12,
  parameter int FIRST_WORD = 6,
  parameter int LAST_WORD  = 29,
  parameter int LO_F       = 200,
  parameter int SPLIT_F    = 450,
  parameter int HI_F       = 1000,
  parameter logic [IMG_BITS-1:0] IMG_20X = make_image(16'h2000, 16'h0313),
  parameter logic [IMG_BITS-1:0] IMG_10X = make_image(16'h1000, 16'h0313),
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     rd_mode_i,
  input  logic                     force_20x_i,
  input  logic [FW-1:0]            freq_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     err_low_o,
  output logic                     err_high_o,
  output logic [NPORT*ADDR_W-1:0]  pll_addr_o,
  output logic [NPORT*DATA_W-1:0]  pll_wdata_o,
  output logic [NPORT-1:0]         pll_we_o,
  output logic [NPORT-1:0]         pll_rd_o,
  input  logic [NPORT-1:0]         pll_rdy_i,
  input  logic [NPORT*DATA_W-1:0]  pll_rdata_i,
  output logic                     rb_valid_o,
  output logic [PW-1:0]            rb_port_o,
  output logic [ADDR_W-1:0]        rb_word_o,
  output logic [DATA_W-1:0]        rb_data_o
);

  localparam logic [ADDR_W-1:0] WR_FIRST = ADDR_W'(FIRST_WORD);
  localparam logic [ADDR_W-1:0] WR_LAST  = ADDR_W'(LAST_WORD);
  localparam logic [ADDR_W-1:0] RD_LAST  = ADDR_W'(IMG_WORDS - 1);
  localparam logic [PW-1:0]     PORT_END = PW'(NPORT - 1);

  seq_state_e        state_q;
  logic [PW-1:0]     port_q;
  logic [ADDR_W-1:0] word_q;
  logic              rd_q;
  logic              sel10_q;
  logic              done_q, elo_q, ehi_q;
  logic              rbv_q;
  logic [PW-1:0]     rb_port_q;
  logic [ADDR_W-1:0] rb_word_q;
  logic [DATA_W-1:0] rb_data_q;

  // Named internal events
  logic              use10, bad_lo, bad_hi;
  logic [DATA_W-1:0] img_word;
  logic              rdy_sel;
  logic [DATA_W-1:0] rdata_sel;
  logic              start_ok;
  logic              start_err;
  logic              access_ack;
  logic              word_end;
  logic              op_end;
  logic [ADDR_W-1:0] last_w;
  logic              issue_we, issue_rd;

  pll_band_sel #(
    .FW(FW), .LO_F(LO_F), .SPLIT_F(SPLIT_F), .HI_F(HI_F)
  ) i_band (
    .freq_i     (freq_i),
    .force_i    (force_20x_i),
    .use_10x_o  (use10),
    .err_low_o  (bad_lo),
    .err_high_o (bad_hi)
  );

  pll_image_rom #(
    .IMG_A(IMG_20X), .IMG_B(IMG_10X)
  ) i_rom (
    .sel_b_i (sel10_q),
    .idx_i   (word_q),
    .word_o  (img_word)
  );

  assign issue_we = (state_q == ST_ISSUE) && !rd_q;
  assign issue_rd = (state_q == ST_ISSUE) && rd_q;

  pll_port_fanout #(
    .NPORT(NPORT), .PW(PW)
  ) i_fanout (
    .act_i       (state_q != ST_IDLE),
    .port_i      (port_q),
    .addr_i      (word_q),
    .wdata_i     (rd_q ? '0 : img_word),
    .we_i        (issue_we),
    .rd_i        (issue_rd),
    .pll_addr_o  (pll_addr_o),
    .pll_wdata_o (pll_wdata_o),
    .pll_we_o    (pll_we_o),
    .pll_rd_o    (pll_rd_o),
    .pll_rdy_i   (pll_rdy_i),
    .pll_rdata_i (pll_rdata_i),
    .rdy_o       (rdy_sel),
    .rdata_o     (rdata_sel)
  );

  assign start_ok   = start_i && (state_q == ST_IDLE);
  assign start_err  = start_ok && !rd_mode_i && (bad_lo || bad_hi);
  assign last_w     = rd_q ? RD_LAST : WR_LAST;
  assign access_ack = (state_q == ST_WAIT) && rdy_sel;
  assign word_end   = access_ack && (word_q == last_w);
  assign op_end     = word_end && (port_q == PORT_END);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      port_q    <= '0;
      word_q    <= '0;
      rd_q      <= 1'b0;
      sel10_q   <= 1'b0;
      done_q    <= 1'b0;
      elo_q     <= 1'b0;
      ehi_q     <= 1'b0;
      rbv_q     <= 1'b0;
      rb_port_q <= '0;
      rb_word_q <= '0;
      rb_data_q <= '0;
    end else begin
      done_q <= 1'b0;
      elo_q  <= 1'b0;
      ehi_q  <= 1'b0;
      rbv_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_err) begin
            done_q <= 1'b1;
            elo_q  <= bad_lo;
            ehi_q  <= bad_hi;
          end else if (start_ok) begin
            rd_q    <= rd_mode_i;
            sel10_q <= rd_mode_i ? 1'b0 : use10;
            port_q  <= '0;
            word_q  <= rd_mode_i ? '0 : WR_FIRST;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (access_ack) begin
            if (rd_q) begin
              rbv_q     <= 1'b1;
              rb_port_q <= port_q;
              rb_word_q <= word_q;
              rb_data_q <= rdata_sel;
            end
            if (op_end) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else if (word_end) begin
              port_q  <= port_q + PW'(1);
              word_q  <= rd_q ? '0 : WR_FIRST;
              state_q <= ST_ISSUE;
            end else begin
              word_q  <= word_q + ADDR_W'(1);
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_low_o  = elo_q;
  assign err_high_o = ehi_q;
  assign rb_valid_o = rbv_q;
  assign rb_port_o  = rb_port_q;
  assign rb_word_o  = rb_word_q;
  assign rb_data_o  = rb_data_q;

  // ---------------- assertions ----------------
  assert_quiet_after_reset_R1: assert property (@(posedge clk_i)
    !$past(rst_ni) |-> !busy_o && !done_o && !rb_valid_o && !(|pll_we_o) && !(|pll_rd_o));

  assert_write_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pll_we_o) |-> (word_q >= WR_FIRST) && (word_q <= WR_LAST));

  assert_port_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && (port_q != $past(port_q)))
      |-> (port_q == $past(port_q) + PW'(1)) && (state_q == ST_ISSUE));

  assert_strobe_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pll_we_o, pll_rd_o}));

  assert_strobe_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{pll_we_o, pll_rd_o}) |=> !(|{pll_we_o, pll_rd_o}));

  assert_hold_until_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WAIT) && !rdy_sel) |=> (state_q == ST_WAIT) && $stable(word_q) && $stable(port_q));

  assert_error_no_access_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_low_o || err_high_o) |-> done_o && !busy_o && !(|pll_we_o));

  assert_rb_only_readback_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_valid_o |-> rd_q);

  assert_done_when_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_busy_ignores_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !access_ack) |=> busy_o && $stable(rd_q) && $stable(sel10_q));

endmodule

// File: tb/test_pll_reconfig_seq.sv
module test_pll_reconfig_seq;

  localparam int NP = 3;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int MAXEV = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rd_mode = 1'b0, force20 = 1'b0;
  logic [11:0] freq = '0;
  logic busy, done, elo, ehi;
  logic [NP*AW-1:0] addr;
  logic [NP*DW-1:0] wdata;
  logic [NP-1:0] we, rd;
  logic [NP-1:0] rdy = '0;
  logic [NP*DW-1:0] rdata = '0;
  logic rbv;
  logic [1:0] rbp;
  logic [AW-1:0] rbw;
  logic [DW-1:0] rbd;

  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  pll_reconfig_seq i_pll_reconfig_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_mode_i(rd_mode),
    .force_20x_i(force20), .freq_i(freq), .busy_o(busy), .done_o(done),
    .err_low_o(elo), .err_high_o(ehi), .pll_addr_o(addr), .pll_wdata_o(wdata),
    .pll_we_o(we), .pll_rd_o(rd), .pll_rdy_i(rdy), .pll_rdata_i(rdata),
    .rb_valid_o(rbv), .rb_port_o(rbp), .rb_word_o(rbw), .rb_data_o(rbd)
  );

  // ---------- bench reference functions ----------
  function automatic logic [15:0] exp_img(input bit ten_x, input int w);
    int v;
    v = (ten_x ? 4096 : 8192) + w * 787;
    return v[15:0];
  endfunction

  function automatic logic [15:0] port_val(input int p, input int w);
    return 16'(16'hA5C3 ^ (p * 16'h1111) ^ (w * 16'h0101));
  endfunction

  // 0 = 20x, 1 = 10x, 2 = too low, 3 = too high
  function automatic int exp_band(input bit frc, input int f);
    if (frc) return 0;
    if (f > 1000) return 3;
    if (f < 200) return 2;
    return (f > 450) ? 1 : 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // ---------- port model and monitor ----------
  int ev_n, ev_p[MAXEV], ev_a[MAXEV], ev_d[MAXEV], ev_k[MAXEV];
  int rb_n, rb_p[MAXEV], rb_w[MAXEV], rb_d[MAXEV];
  int proto_err;
  bit pend;
  int pend_p, pend_w, cnt;

  initial begin
    pend = 0; proto_err = 0; ev_n = 0; rb_n = 0; cnt = 0; pend_p = 0; pend_w = 0;
    forever begin
      @(negedge clk);
      if (pend && rdy[pend_p]) pend = 0;
      if (rbv && rb_n < MAXEV) begin
        rb_p[rb_n] = int'(rbp); rb_w[rb_n] = int'(rbw); rb_d[rb_n] = int'(rbd);
        rb_n++;
      end
      rdy = '0;
      if (|{we, rd}) begin
        for (int p = 0; p < NP; p++) begin
          if (we[p] || rd[p]) begin
            if (pend) proto_err++;
            pend = 1; pend_p = p; pend_w = int'(addr[p*AW +: AW]);
            cnt = 1 + int'($urandom % 3);
            if (ev_n < MAXEV) begin
              ev_p[ev_n] = p; ev_a[ev_n] = pend_w;
              ev_d[ev_n] = int'(wdata[p*DW +: DW]); ev_k[ev_n] = we[p] ? 1 : 2;
              ev_n++;
            end
          end
        end
      end else if (pend) begin
        cnt--;
        if (cnt == 0) begin
          rdy[pend_p] = 1'b1;
          rdata[pend_p*DW +: DW] = port_val(pend_p, pend_w);
        end
      end
      if (pend && ($urandom % 3 == 0)) begin
        int jp;
        jp = (pend_p + 1 + int'($urandom % 2)) % NP;
        rdy[jp] = 1'b1;
        rdata[jp*DW +: DW] = 16'($urandom);
      end
    end
  end

  // ---------- operation driver ----------
  task automatic run_op(input bit frc, input int f, input bit rdm, input bit poke);
    int band, exp_n, bad, tmo, bad_rb, first_word, last_word, nw;
    bit got_lo, got_hi, got_busy;
    @(negedge clk);
    ev_n = 0; rb_n = 0; proto_err = 0;
    force20 = frc; freq = 12'(f); rd_mode = rdm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tmo = 0;
    while (!done && tmo < 5000) begin
      if (poke && tmo == 40) begin
        start = 1'b1; rd_mode = ~rdm; force20 = ~frc; freq = 12'(f ^ 12'h3FF);
      end else start = 1'b0;
      @(negedge clk);
      tmo++;
    end
    start = 1'b0;
    got_lo = elo; got_hi = ehi; got_busy = busy;
    chk(tmo < 5000, "R9 done pulse seen", tmo, 0);
    chk(!got_busy, "R9 busy low at done", int'(got_busy), 0);
    band = rdm ? 0 : exp_band(frc, f);
    chk(got_lo == (band == 2), "R7 too-low flag", int'(got_lo), int'(band == 2));
    chk(got_hi == (band == 3), "R7 too-high flag", int'(got_hi), int'(band == 3));
    first_word = rdm ? 0 : 6;
    last_word  = rdm ? 31 : 29;
    nw = last_word - first_word + 1;
    exp_n = (band >= 2) ? 0 : NP * nw;
    chk(ev_n == exp_n, "R2/R3/R8 access count", ev_n, exp_n);
    bad = -1;
    for (int i = 0; i < ev_n && i < exp_n; i++) begin
      int ep, ew;
      ep = i / nw; ew = first_word + i % nw;
      if (ev_p[i] != ep || ev_a[i] != ew || ev_k[i] != (rdm ? 2 : 1) ||
          (!rdm && ev_d[i] != int'(exp_img(band == 1, ew)))) begin
        if (bad < 0) bad = i;
      end
    end
    if (rdm) chk(bad < 0, "R8/R3 read order", bad, -1);
    else if (frc) chk(bad < 0, "R5/R2/R3 forced 20x writes", bad, -1);
    else chk(bad < 0, "R6/R2/R3 band image writes", bad, -1);
    chk(proto_err == 0, "R4 strobe only after ready", proto_err, 0);
    if (rdm) begin
      chk(rb_n == NP * 32, "R8 readback count", rb_n, NP * 32);
      bad_rb = -1;
      for (int i = 0; i < rb_n && i < NP * 32; i++) begin
        if (rb_p[i] != i / 32 || rb_w[i] != i % 32 ||
            rb_d[i] != int'(port_val(i / 32, i % 32)))
          if (bad_rb < 0) bad_rb = i;
      end
      chk(bad_rb < 0, "R8 readback values", bad_rb, -1);
    end else begin
      chk(rb_n == 0, "R8 no readback on write", rb_n, 0);
    end
  endtask

  // ---------- watchdog ----------
  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // ---------- main ----------
  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rbv && !(|we) && !(|rd) && !elo && !ehi,
        "R1 reset outputs", int'({busy, done, rbv, |we, |rd}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !(|we) && !(|rd), "R1 first cycle after reset",
        int'({busy, done, |we, |rd}), 0);

    run_op(1'b1, 50,   1'b0, 1'b0);   // R5 forced, out of band low
    run_op(1'b1, 3000, 1'b0, 1'b0);   // R5 forced, out of band high
    run_op(1'b0, 200,  1'b0, 1'b0);   // R6 lower edge
    run_op(1'b0, 450,  1'b0, 1'b0);   // R6 split edge 20x
    run_op(1'b0, 451,  1'b0, 1'b0);   // R6 split edge 10x
    run_op(1'b0, 1000, 1'b0, 1'b0);   // R6 top edge
    run_op(1'b0, 199,  1'b0, 1'b0);   // R7 too low
    run_op(1'b0, 1001, 1'b0, 1'b0);   // R7 too high
    run_op(1'b0, 5,    1'b1, 1'b0);   // R8 readback ignores band
    run_op(1'b0, 700,  1'b0, 1'b1);   // R9 start while busy ignored
    run_op(1'b1, 300,  1'b1, 1'b1);   // R9 start during readback ignored

    for (int t = 0; t < 8; t++) begin
      run_op(1'($urandom % 2), int'($urandom % 1200), 1'($urandom % 4 == 0), 1'b0);
    end

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule